// File: doc/BRIEF.md
# Two-Bank Interrupt Request Combiner

This block gathers raw interrupt events into two 32-bit pending banks. Each bank has its own enable mask. From the two banks it makes a fast-interrupt request and a normal-interrupt request for a processor. A source announces an event with a single-cycle pulse on its bit of `src_pulse`. The pulse sets a sticky pending bit, and that bit stays set until software reads the bank's pending register.

Software reaches the block through a simple register bus. Each bank has three registers: a pending register, an enable mask and an enable-clear port. Reading a pending register returns the whole bank and empties it in the same access. The masked pending bits of both banks are ORed into one 32-bit word. Bit 0 of that word drives the fast request. Bits 1 to 15 drive the normal request. Both request outputs are active-low and registered.

Address map, word index on `bus_addr`: bit 2 selects the bank (0 or 1) and bits 1:0 select the register. Code 0 is pending (read-to-clear), 1 is enable (read/write), 2 is enable-clear (write-only) and 3 is unused.

Top module: `dbintc_top`

## Requirements
- R1: During and after a synchronous reset, both enable masks and both pending banks hold zero, `fiq_n` and `irq_n` are 1, and `bus_rdata` is 0.
- R2: A 1 on bit `32*b+i` of `src_pulse` in any cycle sets pending bit i of bank b at that clock edge, and the bit stays set until the bank is read.
- R3: `fiq_n` is low exactly when bit 0 of (pending0 & enable0) | (pending1 & enable1) was set on the previous clock edge, so it follows a pending or mask change one cycle later.
- R4: `irq_n` is low exactly when any of bits 1 to 15 of the same combined word was set on the previous clock edge. Bits 16 to 31 affect neither output.
- R5: A read (`bus_en`=1, `bus_we`=0) of register code 0 puts the bank's pending value on `bus_rdata` in the following cycle and clears that bank's pending bits at the same edge.
- R6: A source pulse in the same cycle as a read-to-clear of its bank leaves its pending bit set after the clear.
- R7: A write to register code 1 replaces the bank's enable mask with `bus_wdata`. A read of code 1 returns the mask.
- R8: A write to register code 2 clears exactly the written 1 bits of that bank's mask (mask & ~data). Repeating the same write changes nothing.
- R9: Writes to code 0 and code 3 change no state. Reads of codes 2 and 3 return 0.
- R10: `bus_addr[2]` selects the bank, and an access to one bank never changes the other bank's pending bits or mask.
- R11: `bus_rdata` is 0 in every cycle that does not follow a read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pulse | input | 64 | Event pulses: bits 31:0 feed bank 0, bits 63:32 feed bank 1 |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Bank (bit 2) and register code (bits 1:0) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read, otherwise 0 |
| fiq_n | output | 1 | Active-low fast-interrupt request |
| irq_n | output | 1 | Active-low normal-interrupt request |

## Verification
A pending or mask bit in the wrong state shows up at the ports in one of two ways. If it lies in bits 0 to 15, it changes a request pin one cycle after the bad edge. In any position, it is returned by the next read of that bank. A faulty clear path shows up as a stale nonzero value on the second of two back-to-back reads. A lost coincident event shows up as a zero where the model expects the bit. A reference model steps both banks every clock and compares both request pins and the read data each cycle. The first divergence is therefore reported within a cycle of the access that exposes it.

// File: rtl/dbintc_pkg.sv
package dbintc_pkg;
  localparam int REG_FIELD_W = 2;

  typedef enum logic [REG_FIELD_W-1:0] {
    RSEL_PENDING = 2'd0,
    RSEL_ENABLE  = 2'd1,
    RSEL_ENCLR   = 2'd2,
    RSEL_UNUSED  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic rd_clr;
    logic mask_wr;
    logic mask_clr;
  } bank_ctl_t;
endpackage

// File: rtl/dbintc_bank.sv
module dbintc_bank #(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DATA_W-1:0]    src,
  input  dbintc_pkg::bank_ctl_t ctl,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    pending,
  output logic [DATA_W-1:0]    mask
);
  logic [DATA_W-1:0] pend_base;

  // Incoming pulses are ORed after the clear, so they win over it.
  assign pend_base = ctl.rd_clr ? '0 : pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= '0;
    end else begin
      pending <= pend_base | src;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '0;
    end else if (ctl.mask_wr) begin
      mask <= wdata;
    end else if (ctl.mask_clr) begin
      mask <= mask & ~wdata;
    end
  end

  // R2 / R6: every pulsed bit is pending after the edge, even under a clear
  p_src_sets_r6: assert property (@(posedge clk) disable iff (rst)
    (|src) |=> ((pending & $past(src)) == $past(src)));

  // R5: a clear with no new pulse empties the bank
  p_clear_empties_r5: assert property (@(posedge clk) disable iff (rst)
    (ctl.rd_clr && src == '0) |=> (pending == '0));

  // R2: without a clear, no pending bit falls
  p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    !ctl.rd_clr |=> ((pending & $past(pending)) == $past(pending)));

  // R8: bits named by an enable-clear are gone afterwards
  p_enclr_r8: assert property (@(posedge clk) disable iff (rst)
    (ctl.mask_clr && !ctl.mask_wr) |=> ((mask & $past(wdata)) == '0));

  // R9: mask holds when neither mask command is given
  p_mask_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!ctl.mask_clr && !ctl.mask_wr) |=> $stable(mask));
endmodule

// File: rtl/dbintc_req.sv
module dbintc_req #(
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 2,
  parameter int FAST_BIT  = 0,
  parameter int NORM_LO   = 1,
  parameter int NORM_HI   = 15
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_BANKS*DATA_W-1:0]   masked_flat,
  output logic                          fiq_n,
  output logic                          irq_n
);
  logic [DATA_W-1:0] combined;
  logic [DATA_W-1:0] norm_sel;

  always_comb begin
    combined = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      combined = combined | masked_flat[b*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    norm_sel = '0;
    for (int i = NORM_LO; i <= NORM_HI; i++) begin
      norm_sel[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fiq_n <= 1'b1;
      irq_n <= 1'b1;
    end else begin
      fiq_n <= ~combined[FAST_BIT];
      irq_n <= ~|(combined & norm_sel);
    end
  end

  // R4: the normal request moves only when its own bit range moved
  p_irq_range_r4: assert property (@(posedge clk) disable iff (rst)
    $stable(combined & norm_sel) |=> $stable(irq_n));

  // R3: the fast request moves only when its bit moved
  p_fiq_bit_r3: assert property (@(posedge clk) disable iff (rst)
    $stable(combined[FAST_BIT]) |=> $stable(fiq_n));
endmodule

// File: rtl/dbintc_top.sv
module dbintc_top #(
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 2,
  parameter int FAST_BIT  = 0,
  parameter int NORM_LO   = 1,
  parameter int NORM_HI   = 15,
  localparam int BANK_AW  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W   = dbintc_pkg::REG_FIELD_W + BANK_AW,
  localparam int SRC_W    = NUM_BANKS * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_W-1:0]  src_pulse,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              fiq_n,
  output logic              irq_n
);
  import dbintc_pkg::*;

  reg_sel_e           rsel;
  logic [BANK_AW-1:0] bank_idx;
  logic               rd_acc;
  logic               wr_acc;
  logic [SRC_W-1:0]   pend_flat;
  logic [SRC_W-1:0]   mask_flat;
  logic [SRC_W-1:0]   masked_flat;
  logic [DATA_W-1:0]  rd_word;

  assign rsel     = reg_sel_e'(bus_addr[REG_FIELD_W-1:0]);
  assign bank_idx = bus_addr[ADDR_W-1:REG_FIELD_W];
  assign rd_acc   = bus_en & ~bus_we;
  assign wr_acc   = bus_en & bus_we;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_ctl_t ctl;
    logic      hit;

    assign hit          = (bank_idx == BANK_AW'(b));
    assign ctl.rd_clr   = rd_acc & hit & (rsel == RSEL_PENDING);
    assign ctl.mask_wr  = wr_acc & hit & (rsel == RSEL_ENABLE);
    assign ctl.mask_clr = wr_acc & hit & (rsel == RSEL_ENCLR);

    dbintc_bank #(.DATA_W(DATA_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .src     (src_pulse[b*DATA_W +: DATA_W]),
      .ctl     (ctl),
      .wdata   (bus_wdata),
      .pending (pend_flat[b*DATA_W +: DATA_W]),
      .mask    (mask_flat[b*DATA_W +: DATA_W])
    );

    assign masked_flat[b*DATA_W +: DATA_W] =
      pend_flat[b*DATA_W +: DATA_W] & mask_flat[b*DATA_W +: DATA_W];
  end

  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_idx == BANK_AW'(b)) begin
        case (rsel)
          RSEL_PENDING: rd_word = pend_flat[b*DATA_W +: DATA_W];
          RSEL_ENABLE:  rd_word = mask_flat[b*DATA_W +: DATA_W];
          default:      rd_word = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= rd_acc ? rd_word : '0;
    end
  end

  dbintc_req #(
    .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .FAST_BIT(FAST_BIT),
    .NORM_LO(NORM_LO), .NORM_HI(NORM_HI)
  ) u_req (
    .clk         (clk),
    .rst         (rst),
    .masked_flat (masked_flat),
    .fiq_n       (fiq_n),
    .irq_n       (irq_n)
  );

  // R11: no read access, no read data
  p_rdata_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_acc |=> (bus_rdata == '0));

  // R1: reset leaves the request pins inactive
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (fiq_n && irq_n && bus_rdata == '0));
endmodule

// File: tb/dbintc_top_tb.sv
module dbintc_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src_pulse = '0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fiq_n, irq_n;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dbintc_top u_dut (
    .clk(clk), .rst(rst), .src_pulse(src_pulse), .bus_en(bus_en),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .fiq_n(fiq_n), .irq_n(irq_n)
  );

  // Behavioural reference model
  logic [31:0] m_pend [2];
  logic [31:0] m_en   [2];
  logic        e_fiq = 1'b1, e_irq = 1'b1;
  logic [31:0] e_rd = '0;

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 2; k++) begin m_pend[k] = '0; m_en[k] = '0; end
      e_fiq = 1'b1; e_irq = 1'b1; e_rd = '0;
    end else begin
      logic [31:0] any;
      int bk;
      int code;
      any = (m_pend[0] & m_en[0]) | (m_pend[1] & m_en[1]);
      e_fiq = !any[0];
      e_irq = !(|any[15:1]);
      bk = int'(bus_addr[2]);
      code = int'(bus_addr[1:0]);
      e_rd = '0;
      if (bus_en && !bus_we) begin
        if (code == 0) e_rd = m_pend[bk];
        else if (code == 1) e_rd = m_en[bk];
      end
      for (int k = 0; k < 2; k++) begin
        if (bus_en && !bus_we && code == 0 && bk == k) m_pend[k] = '0;
        m_pend[k] = m_pend[k] | src_pulse[k*32 +: 32];
        if (bus_en && bus_we && bk == k) begin
          if (code == 1) m_en[k] = bus_wdata;
          else if (code == 2) m_en[k] = m_en[k] & ~bus_wdata;
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (!rst && !done) begin
      check("R3 fiq_n", {31'd0, fiq_n}, {31'd0, e_fiq});
      check("R4 irq_n", {31'd0, irq_n}, {31'd0, e_irq});
      check("R5/R11 bus_rdata", bus_rdata, e_rd);
    end
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // One bus cycle: drive at a falling edge, return at the next one
  task automatic op(input logic en, input logic we, input logic [2:0] a,
                    input logic [31:0] d, input logic [63:0] s);
    bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d; src_pulse = s;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; src_pulse = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    op(1'b1, 1'b0, a, '0, '0);
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(1'b0, 1'b0, '0, '0, '0);
  endtask

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    // R1: outputs during reset
    check("R1 fiq_n in reset", {31'd0, fiq_n}, 32'd1);
    check("R1 irq_n in reset", {31'd0, irq_n}, 32'd1);
    check("R1 rdata in reset", bus_rdata, 32'd0);
    rst = 1'b0;
    idle(2);
    rd(3'd1, v); check("R1 enable0 after reset", v, 32'd0);
    rd(3'd4, v); check("R1 pending1 after reset", v, 32'd0);

    // R2: bank 1 bit 20 latches and holds
    op(1'b0, 1'b0, '0, '0, 64'd1 << 52);
    idle(3);
    rd(3'd4, v); check("R2 pending1 bit20", v, 32'h0010_0000);
    rd(3'd4, v); check("R5 pending1 cleared by read", v, 32'd0);

    // R7: mask replace and read back; R10: other bank untouched
    op(1'b1, 1'b1, 3'd1, 32'h0000_8001, '0);
    check("R11 rdata after write", bus_rdata, 32'd0);
    rd(3'd1, v); check("R7 enable0 readback", v, 32'h0000_8001);
    rd(3'd5, v); check("R10 enable1 untouched", v, 32'd0);

    // R3: fast request latency
    op(1'b0, 1'b0, '0, '0, 64'd1);
    check("R3 fiq_n one cycle after pending", {31'd0, fiq_n}, 32'd1);
    idle(1);
    check("R3 fiq_n asserted", {31'd0, fiq_n}, 32'd0);
    check("R4 irq_n idle with bit0 only", {31'd0, irq_n}, 32'd1);

    // R4: bit 31 does nothing, bit 15 asserts the normal request
    op(1'b1, 1'b1, 3'd5, 32'h8000_8000, '0);
    op(1'b0, 1'b0, '0, '0, 64'd1 << 63);
    idle(2);
    check("R4 bit31 ignored", {31'd0, irq_n}, 32'd1);
    op(1'b0, 1'b0, '0, '0, 64'd1 << 47);
    idle(1);
    check("R4 irq_n asserted by bit15", {31'd0, irq_n}, 32'd0);

    // R8: enable-clear removes bit 15 only, idempotent
    op(1'b1, 1'b1, 3'd6, 32'h0000_8000, '0);
    idle(1);
    check("R8 irq_n released", {31'd0, irq_n}, 32'd1);
    op(1'b1, 1'b1, 3'd6, 32'h0000_8000, '0);
    rd(3'd5, v); check("R8 enable1 after clears", v, 32'h8000_0000);

    // R9: ignored writes and zero reads
    op(1'b1, 1'b1, 3'd0, 32'hFFFF_FFFF, '0);
    op(1'b1, 1'b1, 3'd3, 32'hFFFF_FFFF, '0);
    rd(3'd2, v); check("R9 enclr reads zero", v, 32'd0);
    rd(3'd3, v); check("R9 unused reads zero", v, 32'd0);
    rd(3'd1, v); check("R9 enable0 unchanged", v, 32'h0000_8001);
    rd(3'd0, v); check("R9 pending0 unchanged", v, 32'h0000_0001);
    idle(1);
    check("R5 fiq_n released after clear", {31'd0, fiq_n}, 32'd1);

    // R6: pulse coincides with the clear
    op(1'b1, 1'b0, 3'd0, '0, 64'h20);
    check("R6 read returns old value", bus_rdata, 32'd0);
    rd(3'd0, v); check("R6 coincident pulse kept", v, 32'h0000_0020);

    // Random traffic checked by the model every cycle
    for (int n = 0; n < 4000; n++) begin
      logic [63:0] s;
      logic [2:0] a;
      s = {$urandom & $urandom & $urandom & $urandom,
           $urandom & $urandom & $urandom & $urandom};
      a = 3'($urandom);
      op(($urandom % 3) != 0, $urandom % 2 == 0, a, $urandom, s);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule